// File: doc/BRIEF.md
# Mode Register Programming Sequencer

This block sits on the controller side of a graphics DDR memory interface and writes the memory's mode register when the memory is first brought up and whenever it is reconfigured. A single-cycle `start` pulse carries the target settings: burst length code, burst type, CAS latency code and the DLL reset request. The sequencer checks the request, then drives a fixed command sequence on the chip-select, row strobe, column strobe and write-enable pins, the address bus and the bank address bits.

If the extended register has not been written yet (`emr_pending` high), the sequencer writes it first, using bank bits 01 and the word on `emr_word`. It then issues precharge-all and waits the row precharge time. Next it writes the main register with bank bits 00 and the encoded settings word. Finally it waits out the mode register delay and pulses `done`. Every cycle without a command carries a NOP.

There is no data stream in this block. `start`, `busy`, `done` and `err` are plain control and status pins. A request made while `busy` is high is not queued and not acknowledged. The caller waits for `busy` to fall before making a new request. The parameters `TRP` and `TMRD` are counted in clock cycles, and both must be at least 2.

Top module: `modereg_sequencer`

## Requirements
- R1: After reset, and in every cycle that carries no command, the pins show NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1) with `addr`=0 and `ba`=0. `busy`, `done` and `err` are low after reset.
- R2: When an accepted start is made with `emr_pending` low, the cycle after the start edge carries precharge-all. Its encoding is `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, `addr` bit 10 = 1, all other address bits 0, and `ba`=00.
- R3: The main register write (`cs_n`, `ras_n`, `cas_n`, `we_n` all 0, `ba`=00) appears exactly `TRP` cycles after the precharge-all cycle.
- R4: The main register write carries this address word: bits 2..0 = burst length code, bit 3 = burst type (1 means interleave), bits 6..4 = CAS latency code, bit 8 = DLL reset request. Bit 7 and bits 11..9 are 0.
- R5: When `emr_pending` is high at an accepted start, the first command, one cycle after the start edge, is a register write with `ba`=01 and `addr`=`emr_word`. Precharge-all follows exactly `TMRD` cycles later, and the rest of the sequence keeps the timing of R2 and R3.
- R6: After the main register write there are `TMRD`-1 NOP cycles. `done` is high for exactly one cycle, the last of those NOP cycles.
- R7: A burst length code other than 001, 010 or 011, or a CAS latency code other than 011 or 100, raises `err` for exactly one cycle, the cycle after the start edge. No command is issued and `busy` stays low.
- R8: A start made while `cke` is low or `banks_idle` is low raises `err` the same way and issues no command.
- R9: A start made while `busy` is high is ignored: the running sequence keeps its timing and its address word, and no second sequence follows.
- R10: `busy` rises in the cycle after an accepted start, stays high through the `done` cycle and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; settings are sampled with it |
| cfg_burst_len | input | 3 | Burst length code (001=2, 010=4, 011=8) |
| cfg_interleave | input | 1 | Burst type, 1 = interleave |
| cfg_cas_lat | input | 3 | CAS latency code (011=3, 100=4) |
| cfg_dll_reset | input | 1 | Request a DLL reset with this write |
| emr_pending | input | 1 | Extended register still needs writing |
| emr_word | input | ADDR_W | Address word for the extended register write |
| cke | input | 1 | Memory clock enable, must be high at start |
| banks_idle | input | 1 | All banks are idle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Memory address bus |
| ba | output | BA_W | Bank address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The bench goes after the spacing between commands. A wait counter that is off by one would put the main write one cycle early or late after the precharge, or put the precharge too close behind the extended write, and both show up as the wrong cycle index. It also sends reserved codes, a non-idle memory and a low clock enable. A design that skipped any of these checks would issue commands that should never appear. Finally, it makes a second request mid-sequence with different settings. A design that re-latched them would write the wrong word, and one that restarted would issue extra commands or stretch `busy`.

// File: rtl/modereg_pkg.sv
package modereg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EMRS,
    ST_EMRS_WAIT,
    ST_PRE,
    ST_PRE_WAIT,
    ST_MRS,
    ST_MRD_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_MRS
  } cmd_t;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [2:0] cl;
    logic       dll;
  } mode_cfg_t;

  function automatic logic bl_code_ok(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic cl_code_ok(input logic [2:0] code);
    return (code == 3'b011) || (code == 3'b100);
  endfunction

endpackage

// File: rtl/modereg_cfg_check.sv
module modereg_cfg_check
  import modereg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  mode_cfg_t          cfg,
  output logic               cfg_ok,
  output logic [ADDR_W-1:0]  cfg_word
);
  // field positions that the memory decodes
  localparam int BL_LSB  = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int DLL_BIT = 8;

  assign cfg_ok = bl_code_ok(cfg.bl) && cl_code_ok(cfg.cl);

  always_comb begin
    cfg_word                    = '0;
    cfg_word[BL_LSB +: 3]       = cfg.bl;
    cfg_word[BT_BIT]            = cfg.bt;
    cfg_word[CL_LSB +: 3]       = cfg.cl;
    cfg_word[DLL_BIT]           = cfg.dll;
  end
endmodule

// File: rtl/modereg_wait_timer.sv
module modereg_wait_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/modereg_cmd_drive.sv
module modereg_cmd_drive
  import modereg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 10
) (
  input  cmd_t              cmd,
  input  logic [ADDR_W-1:0] word,
  input  logic [BA_W-1:0]   bank,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    ba    = '0;
    unique case (cmd)
      CMD_PRE: begin
        ras_n        = 1'b0;
        we_n         = 1'b0;
        addr[AP_BIT] = 1'b1;
      end
      CMD_MRS: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
        addr  = word;
        ba    = bank;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/modereg_sequencer.sv
module modereg_sequencer
  import modereg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int TRP    = 3,
  parameter int TMRD   = 2,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_dll_reset,
  input  logic              emr_pending,
  input  logic [ADDR_W-1:0] emr_word,
  input  logic              cke,
  input  logic              banks_idle,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int MAX_GAP = (TRP > TMRD) ? TRP : TMRD;
  localparam int TMR_W   = $clog2(MAX_GAP + 1);
  localparam logic [TMR_W-1:0] PRE_LOAD = TMR_W'(TRP - 2);
  localparam logic [TMR_W-1:0] MRD_LOAD = TMR_W'(TMRD - 2);

  mode_cfg_t         req_cfg;
  logic              cfg_ok;
  logic [ADDR_W-1:0] cfg_word;
  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] word_q, emr_q;
  logic              err_q;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              accept, reject;
  cmd_t              cmd;
  logic [ADDR_W-1:0] cmd_word;
  logic [BA_W-1:0]   cmd_bank;

  assign req_cfg = '{bl: cfg_burst_len, bt: cfg_interleave,
                     cl: cfg_cas_lat, dll: cfg_dll_reset};

  modereg_cfg_check #(.ADDR_W(ADDR_W)) u_check (
    .cfg      (req_cfg),
    .cfg_ok   (cfg_ok),
    .cfg_word (cfg_word)
  );

  modereg_wait_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  assign accept = start && (state_q == ST_IDLE) && cfg_ok && cke && banks_idle;
  assign reject = start && (state_q == ST_IDLE) && !(cfg_ok && cke && banks_idle);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE:      if (accept) state_d = emr_pending ? ST_EMRS : ST_PRE;
      ST_EMRS: begin
        tmr_load = 1'b1;
        tmr_val  = MRD_LOAD;
        state_d  = ST_EMRS_WAIT;
      end
      ST_EMRS_WAIT: if (tmr_zero) state_d = ST_PRE;
      ST_PRE: begin
        tmr_load = 1'b1;
        tmr_val  = PRE_LOAD;
        state_d  = ST_PRE_WAIT;
      end
      ST_PRE_WAIT:  if (tmr_zero) state_d = ST_MRS;
      ST_MRS: begin
        tmr_load = 1'b1;
        tmr_val  = MRD_LOAD;
        state_d  = ST_MRD_WAIT;
      end
      ST_MRD_WAIT:  if (tmr_zero) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      emr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= reject;
      if (accept) begin
        word_q <= cfg_word;
        emr_q  <= emr_word;
      end
    end
  end

  always_comb begin
    cmd      = CMD_NOP;
    cmd_word = '0;
    cmd_bank = '0;
    unique case (state_q)
      ST_EMRS: begin
        cmd      = CMD_MRS;
        cmd_word = emr_q;
        cmd_bank = BA_W'(1);
      end
      ST_PRE:  cmd = CMD_PRE;
      ST_MRS: begin
        cmd      = CMD_MRS;
        cmd_word = word_q;
      end
      default: ;
    endcase
  end

  modereg_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_drive (
    .cmd   (cmd),
    .word  (cmd_word),
    .bank  (cmd_bank),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr),
    .ba    (ba)
  );

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_MRD_WAIT) && tmr_zero;
  assign err  = err_q;

  // ---------------- assertions ----------------
  logic        pin_pre, pin_mrs, pin_cmd;
  logic [15:0] since_pre, since_mw;
  logic        pre_seen, mw_seen;

  assign pin_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign pin_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  assign pin_cmd = !cs_n && !(ras_n && cas_n && we_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= '0;
      since_mw  <= '0;
      pre_seen  <= 1'b0;
      mw_seen   <= 1'b0;
    end else begin
      if (pin_pre) begin
        since_pre <= 16'd1;
        pre_seen  <= 1'b1;
      end else if (since_pre != 16'hFFFF) begin
        since_pre <= since_pre + 16'd1;
      end
      if (pin_mrs) begin
        since_mw <= 16'd1;
        mw_seen  <= 1'b1;
      end else if (since_mw != 16'hFFFF) begin
        since_mw <= since_mw + 16'd1;
      end
    end
  end

  assert_pre_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mrs && ba == '0) |-> (pre_seen && since_pre == 16'(TRP)));

  assert_mrd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_cmd && mw_seen) |-> (since_mw >= 16'(TMRD)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!pin_cmd && !busy));

  assert_word_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mrs && ba == '0) |-> (!addr[7] && addr[ADDR_W-1:9] == '0 &&
                               bl_code_ok(addr[2:0]) && cl_code_ok(addr[6:4])));

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/test_modereg_sequencer.sv
module test_modereg_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int BA_W   = 2;
  localparam int TRP    = 3;
  localparam int TMRD   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cfg_burst_len = 3'b010;
  logic cfg_interleave = 1'b0;
  logic [2:0] cfg_cas_lat = 3'b011;
  logic cfg_dll_reset = 1'b0;
  logic emr_pending = 1'b0;
  logic [ADDR_W-1:0] emr_word = '0;
  logic cke = 1'b1;
  logic banks_idle = 1'b1;
  logic cs_n, ras_n, cas_n, we_n, busy, done, err;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0] ba;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modereg_sequencer #(.ADDR_W(ADDR_W), .BA_W(BA_W), .TRP(TRP), .TMRD(TMRD)) i_modereg_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .cfg_cas_lat(cfg_cas_lat), .cfg_dll_reset(cfg_dll_reset),
    .emr_pending(emr_pending), .emr_word(emr_word),
    .cke(cke), .banks_idle(banks_idle),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .busy(busy), .done(done), .err(err)
  );

  // observation record of the last watched window
  int pre_k, mrs_k, emrs_k, done_k, err_k, ncmd, done_cnt, busy_cnt, err_cnt, idle_k, nop_bad;
  logic [ADDR_W-1:0] mrs_addr, emrs_addr, pre_addr;
  logic [BA_W-1:0] pre_ba;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pulses start with the current settings, then samples n cycles.
  // k=1 is the cycle right after the start edge. poke_k>0 re-pulses start mid-run.
  task automatic watch(input int n, input int poke_k);
    pre_k = -1; mrs_k = -1; emrs_k = -1; done_k = -1; err_k = -1; idle_k = -1;
    ncmd = 0; done_cnt = 0; busy_cnt = 0; err_cnt = 0; nop_bad = 0;
    mrs_addr = '0; emrs_addr = '0; pre_addr = '0; pre_ba = '0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= n; k++) begin
      if (!cs_n && !ras_n && cas_n && !we_n) begin
        ncmd++; if (pre_k < 0) begin pre_k = k; pre_addr = addr; pre_ba = ba; end
      end else if (!cs_n && !ras_n && !cas_n && !we_n) begin
        ncmd++;
        if (ba == 2'b01) begin if (emrs_k < 0) begin emrs_k = k; emrs_addr = addr; end end
        else if (mrs_k < 0) begin mrs_k = k; mrs_addr = addr; end
      end else if (!(cs_n == 1'b0 && ras_n && cas_n && we_n)) begin
        ncmd++;
      end else if (addr != '0 || ba != '0) begin
        nop_bad++;
      end
      if (done) begin done_cnt++; if (done_k < 0) done_k = k; end
      if (err)  begin err_cnt++;  if (err_k < 0) err_k = k; end
      if (busy) busy_cnt++;
      else if (idle_k < 0 && busy_cnt > 0) idle_k = k;
      if (k == poke_k) begin
        start = 1'b1;
        cfg_cas_lat = 3'b100;
        cfg_burst_len = 3'b011;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] word_of(input logic [2:0] bl, input logic bt,
                                                input logic [2:0] cl, input logic dll);
    return {3'b000, dll, 1'b0, cl, bt, bl};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk(cs_n == 0 && ras_n && cas_n && we_n, "R1 reset NOP pins", {cs_n, ras_n, cas_n, we_n}, 7);
    chk(addr == 0 && ba == 0, "R1 reset addr/ba", int'(addr), 0);
    chk(!busy && !done && !err, "R1 reset status", {busy, done, err}, 0);
  endtask

  task automatic t_basic;
    logic [ADDR_W-1:0] exp_w;
    cfg_burst_len = 3'b010; cfg_interleave = 0; cfg_cas_lat = 3'b011; cfg_dll_reset = 0;
    emr_pending = 0;
    exp_w = word_of(3'b010, 0, 3'b011, 0);
    watch(12, 0);
    chk(pre_k == 1, "R2 precharge cycle", pre_k, 1);
    chk(pre_addr == 12'h400 && pre_ba == 0, "R2 precharge address", int'(pre_addr), 'h400);
    chk(mrs_k == 1 + TRP, "R3 mode write spacing", mrs_k, 1 + TRP);
    chk(mrs_addr == exp_w, "R4 word BL4 seq CL3", int'(mrs_addr), int'(exp_w));
    chk(done_k == TRP + TMRD && done_cnt == 1, "R6 done position", done_k, TRP + TMRD);
    chk(ncmd == 2 && emrs_k < 0, "R2 command count", ncmd, 2);
    chk(nop_bad == 0, "R1 NOP cycles clean", nop_bad, 0);
    chk(busy_cnt == TRP + TMRD && idle_k == TRP + TMRD + 1, "R10 busy window", busy_cnt, TRP + TMRD);
  endtask

  task automatic t_variant;
    logic [ADDR_W-1:0] exp_w;
    cfg_burst_len = 3'b011; cfg_interleave = 1; cfg_cas_lat = 3'b100; cfg_dll_reset = 1;
    emr_pending = 0;
    exp_w = word_of(3'b011, 1, 3'b100, 1);
    watch(12, 0);
    chk(mrs_addr == exp_w, "R4 word BL8 intl CL4 DLL", int'(mrs_addr), int'(exp_w));
    chk(mrs_k == 1 + TRP, "R3 spacing second pattern", mrs_k, 1 + TRP);
    cfg_burst_len = 3'b001; cfg_interleave = 0; cfg_dll_reset = 0;
    exp_w = word_of(3'b001, 0, 3'b100, 0);
    watch(12, 0);
    chk(mrs_addr == exp_w, "R4 word BL2 seq CL4", int'(mrs_addr), int'(exp_w));
  endtask

  task automatic t_emr;
    cfg_burst_len = 3'b010; cfg_interleave = 0; cfg_cas_lat = 3'b011; cfg_dll_reset = 0;
    emr_pending = 1; emr_word = 12'h042;
    watch(14, 0);
    emr_pending = 0;
    chk(emrs_k == 1 && emrs_addr == 12'h042, "R5 extended write first", emrs_k, 1);
    chk(pre_k == 1 + TMRD, "R5 precharge after extended", pre_k, 1 + TMRD);
    chk(mrs_k == 1 + TMRD + TRP, "R5 main write timing", mrs_k, 1 + TMRD + TRP);
    chk(done_k == TMRD + TRP + TMRD && done_cnt == 1, "R6 done with extended", done_k, 2*TMRD + TRP);
    chk(ncmd == 3, "R5 command count", ncmd, 3);
  endtask

  task automatic t_bad_codes;
    emr_pending = 0; cfg_cas_lat = 3'b011;
    cfg_burst_len = 3'b000;
    watch(8, 0);
    chk(err_k == 1 && err_cnt == 1, "R7 BL 000 err pulse", err_k, 1);
    chk(ncmd == 0 && busy_cnt == 0, "R7 BL 000 no commands", ncmd, 0);
    cfg_burst_len = 3'b100;
    watch(8, 0);
    chk(err_k == 1 && ncmd == 0, "R7 BL 100 rejected", ncmd, 0);
    cfg_burst_len = 3'b010; cfg_cas_lat = 3'b010;
    watch(8, 0);
    chk(err_k == 1 && err_cnt == 1 && ncmd == 0 && busy_cnt == 0, "R7 CL 010 rejected", ncmd, 0);
    cfg_cas_lat = 3'b101;
    watch(8, 0);
    chk(err_k == 1 && ncmd == 0, "R7 CL 101 rejected", ncmd, 0);
    cfg_cas_lat = 3'b011;
  endtask

  task automatic t_not_ready;
    banks_idle = 0;
    watch(8, 0);
    banks_idle = 1;
    chk(err_k == 1 && ncmd == 0 && busy_cnt == 0, "R8 banks busy rejected", ncmd, 0);
    cke = 0;
    watch(8, 0);
    cke = 1;
    chk(err_k == 1 && ncmd == 0 && busy_cnt == 0, "R8 cke low rejected", ncmd, 0);
  endtask

  task automatic t_busy_ignore;
    logic [ADDR_W-1:0] exp_w;
    cfg_burst_len = 3'b010; cfg_interleave = 0; cfg_cas_lat = 3'b011; cfg_dll_reset = 0;
    emr_pending = 0;
    exp_w = word_of(3'b010, 0, 3'b011, 0);
    watch(14, 2);
    chk(mrs_addr == exp_w, "R9 word not re-latched", int'(mrs_addr), int'(exp_w));
    chk(mrs_k == 1 + TRP && done_cnt == 1, "R9 timing kept", mrs_k, 1 + TRP);
    chk(ncmd == 2 && busy_cnt == TRP + TMRD && err_cnt == 0, "R9 no second run", ncmd, 2);
    cfg_burst_len = 3'b010; cfg_cas_lat = 3'b011;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_variant();
    t_emr();
    t_bad_codes();
    t_not_ready();
    t_busy_ignore();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule